// File: doc/BRIEF.md
# External Data-Memory Stretch Sequencer

This block produces the bus timing for a single external data-memory read or write on behalf of a small 8-bit processor core. On a start request it captures the address, the write data, the direction and a 3-bit stretch code. It then steps through four bus phases before reporting completion with a one-clock done pulse. The phases are address latch, setup, strobe and hold. Reads return the byte that was on the data bus just before the read strobe was released.

The stretch code lengthens the access so that slow RAM and peripherals can be attached. One stretch unit is `STRETCH_CLKS` system clocks, and the system clock is taken as undivided. The extra time is not spread evenly across the phases:

- Code 0 gives the plain access.
- Codes 1 to 3 add one clock of setup, one clock of hold, and make the strobe longer by the remainder.
- Codes 4 to 7 count as 7 to 10 stretch units. Two of those units go to setup and one goes to hold. For these codes only, a page miss also widens the address-latch pulse by one unit.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset, ale_o and bus_doe_o are 0, rd_n_o and wr_n_o are 1, and done_o and busy_o are 0.
- R2: With stretch code 0, the address-latch phase lasts 2 clocks, setup 1 clock, strobe 2 clocks and hold 1 clock. The phases run in that order, and done_o follows the hold phase.
- R3: With stretch code k in 1..3, setup is 2 clocks, hold is 2 clocks and the strobe is k*STRETCH_CLKS clocks. The total added time is k stretch units.
- R4: Codes 4..7 stand for 7..10 stretch units. Setup is 1+2*STRETCH_CLKS clocks, hold is 1+STRETCH_CLKS clocks, and the strobe is 2+(units-3)*STRETCH_CLKS clocks.
- R5: page_miss_i, sampled when a start is accepted, widens the address-latch phase by STRETCH_CLKS clocks for codes 4..7 only. It never changes setup, strobe or hold, and it has no effect for codes 0..3.
- R6: A read drives only rd_n_o low, and a write drives only wr_n_o low, during the strobe phase. The two strobes are never low together, and neither is low while ale_o is high.
- R7: On a write, bus_doe_o is high and bus_dout_o equals the captured write data from the first strobe clock to the last hold clock. On a read, bus_doe_o stays 0.
- R8: On a read, rdata_o takes the value of bus_din_i at the clock edge that ends the last strobe clock, and holds it afterwards.
- R9: done_o is high for exactly one clock after hold. busy_o is high from the clock after acceptance through the done clock. A start request made while busy_o is high is ignored.
- R10: bus_addr_o holds the captured address, unchanged, for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access request, accepted only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| stretch_i | input | 3 | Stretch code |
| page_miss_i | input | 1 | Page miss flag for this access |
| bus_din_i | input | DATA_W | Data bus input |
| ale_o | output | 1 | Address latch enable |
| bus_addr_o | output | ADDR_W | Address bus |
| bus_dout_o | output | DATA_W | Data bus output |
| bus_doe_o | output | 1 | Data bus output enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| busy_o | output | 1 | Access in progress |

## Verification
A wrong phase counter or a mis-decoded stretch code shows up as a wrong number of clocks in one phase at the ports. That error appears during the access that uses the bad code, and the bench measures every phase length on every access. A wrong captured direction or address shows up on the strobes or the address bus in the first cycle of the access. A misplaced read sample shows up in rdata_o right after done. For that, the bench presents the correct read byte only while the read strobe is low.

// File: rtl/xmem_stretch_pkg.sv
package xmem_stretch_pkg;

    localparam int CNT_W  = 8;
    localparam int BASE_A = 2;
    localparam int BASE_S = 1;
    localparam int BASE_W = 2;
    localparam int BASE_H = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] ale_len;
        logic [CNT_W-1:0] setup_len;
        logic [CNT_W-1:0] strobe_len;
        logic [CNT_W-1:0] hold_len;
    } timing_t;

    function automatic int stretch_units(input logic [2:0] code);
        return code[2] ? int'(code) + 3 : int'(code);
    endfunction

    function automatic timing_t decode_timing(input logic [2:0] code,
                                              input logic pmiss,
                                              input int sc);
        timing_t t;
        int u;
        u = stretch_units(code);
        t.ale_len    = CNT_W'(BASE_A);
        t.setup_len  = CNT_W'(BASE_S);
        t.strobe_len = CNT_W'(BASE_W);
        t.hold_len   = CNT_W'(BASE_H);
        if (code[2]) begin
            t.setup_len  = CNT_W'(BASE_S + 2 * sc);
            t.hold_len   = CNT_W'(BASE_H + sc);
            t.strobe_len = CNT_W'(BASE_W + (u - 3) * sc);
            if (pmiss) t.ale_len = CNT_W'(BASE_A + sc);
        end else if (code != 3'd0) begin
            t.setup_len  = CNT_W'(BASE_S + 1);
            t.hold_len   = CNT_W'(BASE_H + 1);
            t.strobe_len = CNT_W'(BASE_W + u * sc - 2);
        end
        return t;
    endfunction

endpackage

// File: rtl/xmem_stretch_decode.sv
module xmem_stretch_decode
    import xmem_stretch_pkg::*;
#(
    parameter int STRETCH_CLKS = 4
) (
    input  logic [2:0] code_i,
    input  logic       pmiss_i,
    output timing_t    timing_o
);
    always_comb begin
        timing_o = decode_timing(code_i, pmiss_i, STRETCH_CLKS);
    end
endmodule

// File: rtl/xmem_phase_seq.sv
module xmem_phase_seq
    import xmem_stretch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  timing_t timing_i,
    output logic    accept_o,
    output logic    sample_o,
    output phase_e  phase_o
);
    phase_e           phase_q;
    timing_t          tim_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign accept_o = start_i && (phase_q == PH_IDLE);
    assign last     = (cnt_q == CNT_W'(1));
    assign sample_o = (phase_q == PH_STROBE) && last;
    assign phase_o  = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tim_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept_o) begin
                    phase_q <= PH_ALE;
                    cnt_q   <= timing_i.ale_len;
                    tim_q   <= timing_i;
                end
                PH_ALE: if (last) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= tim_q.setup_len;
                end else cnt_q <= cnt_q - 1'b1;
                PH_SETUP: if (last) begin
                    phase_q <= PH_STROBE;
                    cnt_q   <= tim_q.strobe_len;
                end else cnt_q <= cnt_q - 1'b1;
                PH_STROBE: if (last) begin
                    phase_q <= PH_HOLD;
                    cnt_q   <= tim_q.hold_len;
                end else cnt_q <= cnt_q - 1'b1;
                PH_HOLD: if (last) begin
                    phase_q <= PH_DONE;
                    cnt_q   <= '0;
                end else cnt_q <= cnt_q - 1'b1;
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xmem_bus_drive.sv
module xmem_bus_drive
    import xmem_stretch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              sample_i,
    input  phase_e            phase_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              ale_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              in_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept_i) begin
                wr_q    <= wr_i;
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
            end
            if (sample_i && !wr_q) rdata_q <= bus_din_i;
        end
    end

    assign in_strobe  = (phase_i == PH_STROBE);
    assign ale_o      = (phase_i == PH_ALE);
    assign bus_addr_o = addr_q;
    assign bus_dout_o = wdata_q;
    assign bus_doe_o  = wr_q && (in_strobe || phase_i == PH_HOLD);
    assign rd_n_o     = !(in_strobe && !wr_q);
    assign wr_n_o     = !(in_strobe && wr_q);
    assign rdata_o    = rdata_q;
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
    import xmem_stretch_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int STRETCH_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [2:0]        stretch_i,
    input  logic              page_miss_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              ale_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_doe_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o
);
    timing_t timing;
    logic    accept;
    logic    sample;
    phase_e  phase;

    xmem_stretch_decode #(.STRETCH_CLKS(STRETCH_CLKS)) u_decode (
        .code_i   (stretch_i),
        .pmiss_i  (page_miss_i),
        .timing_o (timing)
    );

    xmem_phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .timing_i (timing),
        .accept_o (accept),
        .sample_o (sample),
        .phase_o  (phase)
    );

    xmem_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .sample_i   (sample),
        .phase_i    (phase),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .bus_din_i  (bus_din_i),
        .ale_o      (ale_o),
        .bus_addr_o (bus_addr_o),
        .bus_dout_o (bus_dout_o),
        .bus_doe_o  (bus_doe_o),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .rdata_o    (rdata_o)
    );

    assign done_o = (phase == PH_DONE);
    assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ale_o,
    input logic              rd_n_o,
    input logic              wr_n_o,
    input logic              bus_doe_o,
    input logic              done_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] bus_addr_o
);
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    p_ale_quiet_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> (rd_n_o && wr_n_o));

    p_wr_drives_bus_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> bus_doe_o);

    p_rd_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> !bus_doe_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    p_done_then_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));
endmodule

bind xmem_stretch_seq xmem_stretch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ale_o      (ale_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .bus_doe_o  (bus_doe_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .bus_addr_o (bus_addr_o)
);

// File: tb/xmem_stretch_seq_tb.sv
module xmem_stretch_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [2:0]    stretch_i = '0;
    logic          page_miss_i = 1'b0;
    logic [DW-1:0] bus_din_i = '0;
    logic          ale_o, bus_doe_o, rd_n_o, wr_n_o, done_o, busy_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_dout_o, rdata_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] rd_val = 8'h00;

    xmem_stretch_seq #(.ADDR_W(AW), .DATA_W(DW), .STRETCH_CLKS(SC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .stretch_i(stretch_i), .page_miss_i(page_miss_i),
        .bus_din_i(bus_din_i), .ale_o(ale_o), .bus_addr_o(bus_addr_o),
        .bus_dout_o(bus_dout_o), .bus_doe_o(bus_doe_o), .rd_n_o(rd_n_o),
        .wr_n_o(wr_n_o), .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bus model: the correct byte is present only while the read strobe is low
    always @(negedge clk) bus_din_i = rd_n_o ? ~rd_val : rd_val;

    function automatic int exp_ale(input int code, input bit pm);
        return (code >= 4 && pm) ? 2 + SC : 2;
    endfunction
    function automatic int exp_setup(input int code);
        if (code == 0) return 1;
        if (code < 4) return 2;
        return 1 + 2 * SC;
    endfunction
    function automatic int exp_strobe(input int code);
        if (code == 0) return 2;
        if (code < 4) return code * SC;
        return 2 + code * SC;   // units (code+3) minus the three spent on setup/hold
    endfunction
    function automatic int exp_hold(input int code);
        if (code == 0) return 1;
        if (code < 4) return 2;
        return 1 + SC;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // one access; if inject>0 a conflicting start is raised in that cycle
    task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                          input int code, input bit pm, input int inject);
        int n_ale = 0, n_set = 0, n_stb = 0, n_hold = 0, n_doe = 0, cyc = 0;
        bit seen_stb = 0, bad_dir = 0, bad_addr = 0, bad_dout = 0, not_busy = 0;
        rd_val = 8'($urandom);
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; addr_i = addr; wdata_i = wd;
        stretch_i = 3'(code); page_miss_i = pm;
        @(negedge clk);
        start_i = 1'b0;
        addr_i = ~addr; wr_i = ~wr; stretch_i = 3'(7 - code); page_miss_i = ~pm;
        while (!done_o && cyc < 200) begin
            if (ale_o) n_ale++;
            else if (!rd_n_o || !wr_n_o) begin
                n_stb++; seen_stb = 1;
                if (wr ? rd_n_o == 0 : wr_n_o == 0) bad_dir = 1;
            end else if (!seen_stb) n_set++;
            else n_hold++;
            if (bus_doe_o) begin
                n_doe++;
                if (bus_dout_o != wd) bad_dout = 1;
            end
            if (bus_addr_o != addr) bad_addr = 1;
            if (!busy_o) not_busy = 1;
            cyc++;
            if (cyc == inject) begin
                start_i = 1'b1; addr_i = addr ^ 16'h5a5a; wr_i = ~wr; stretch_i = 3'd0;
            end else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cyc < 200, "R9 done reached", cyc, 0);
        chk(n_ale == exp_ale(code, pm), $sformatf("R5 ale code %0d pm %0d", code, pm), n_ale, exp_ale(code, pm));
        chk(n_set == exp_setup(code), $sformatf("R2/R3/R4 setup code %0d", code), n_set, exp_setup(code));
        chk(n_stb == exp_strobe(code), $sformatf("R2/R3/R4 strobe code %0d", code), n_stb, exp_strobe(code));
        chk(n_hold == exp_hold(code), $sformatf("R2/R3/R4 hold code %0d", code), n_hold, exp_hold(code));
        chk(!bad_dir, "R6 strobe direction", bad_dir, 0);
        chk(!bad_addr, "R10 address held", bad_addr, 0);
        chk(!not_busy, "R9 busy during access", not_busy, 0);
        chk(n_doe == (wr ? exp_strobe(code) + exp_hold(code) : 0), "R7 data drive window",
            n_doe, wr ? exp_strobe(code) + exp_hold(code) : 0);
        if (wr) chk(!bad_dout, "R7 write data value", bad_dout, 0);
        @(negedge clk);
        chk(!done_o, "R9 done one clock", done_o, 0);
        chk(!busy_o && !ale_o, "R9 idle after done, no queued start", busy_o, 0);
        if (!wr) chk(rdata_o == rd_val, "R8 read sample", rdata_o, rd_val);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!ale_o && rd_n_o && wr_n_o && !bus_doe_o && !done_o && !busy_o,
            "R1 reset outputs", {ale_o, rd_n_o, wr_n_o, bus_doe_o, done_o, busy_o}, 6'b011000);
        // directed: every code, both directions, both page-miss values
        for (int c = 0; c < 8; c++) begin
            access(1'b0, 16'h1000 + 16'(c), 8'h00, c, 1'b0, 0);
            access(1'b1, 16'h2000 + 16'(c), 8'hA0 + 8'(c), c, 1'b1, 0);
            access(1'b0, 16'h3000 + 16'(c), 8'h00, c, 1'b1, 0);
        end
        // R9 starts raised mid-access are ignored
        access(1'b1, 16'hBEEF, 8'h3C, 5, 1'b1, 3);
        access(1'b0, 16'hCAFE, 8'h00, 2, 1'b0, 6);
        access(1'b0, 16'h0F0F, 8'h00, 0, 1'b0, 5);
        // constrained random
        for (int i = 0; i < 60; i++) begin
            access(1'($urandom), 16'($urandom), 8'($urandom), int'($urandom % 8),
                   1'($urandom), int'($urandom % 12));
            repeat (int'($urandom % 3)) @(negedge clk);
        end
        finish_run();
    end
endmodule